// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block steps a processor's control unit through microcode held in a writable control store. The store is divided into one fixed window per opcode, 32 microinstructions deep, and every microinstruction is a wide control word that drives the datapath directly. A microstep counter and a latched opcode together select the word for the current cycle. The first three lines of every window carry the same instruction-fetch sequence, and execution lines begin at line 3. A no-operation instruction is those three fetch lines plus one more line that ends the instruction.

Two bits at the top of each control word steer the sequencer itself. The end-of-instruction bit sends the step counter back to line 0 on the next edge, so short instructions do not walk their whole window. The opcode-capture bit copies the instruction-register input into the opcode latch. Microcode that needs an extra cycle, for example to let a 16-bit increment settle during fetch or a stack transfer, simply spends one more line before its end bit.

At cold start the store is filled through a loader port, one word per write. The sequencer is held idle until the write to the last address has been accepted. Reset clears both the sequencer and the loaded flag, so a fresh load must follow. The default build has 64 opcode slots, which keeps elaboration small. Setting `OP_W` to 8 gives the full 256 slots of 64-bit words.

Top module: `mseq_top`

## Requirements
- R1: While running, `ctl_o` equals the store word at address {`op_o`, `step_o`}, with the opcode in the upper bits and the step in the lower `STEP_W` bits. The same layout is used for `ld_addr`.
- R2: On each running cycle the step advances by one. If the current `ctl_o` has its end bit (bit `CTL_W-1`) set, the next step is 0 instead. A four-line instruction therefore occupies steps 0, 1, 2, 3 and then returns to 0.
- R3: If line 31 has no end bit, the step wraps to 0, so the whole 32-line window is walked.
- R4: If the current `ctl_o` has its capture bit (bit `CTL_W-2`) set, `op_o` takes the value of `ir_in` on the next edge. Otherwise `op_o` is unchanged.
- R5: While `ld_done` is low, `ld_we` writes `ld_data` at `ld_addr`. `ld_done` rises on the edge that accepts a write to the highest address (all ones) and stays high until reset.
- R6: Loader writes made while `ld_done` is high do not change the store.
- R7: While `rst` is high or `ld_done` is low, `step_o` and `op_o` are 0, `ctl_o` is all zeros and `run_o` is low. On the first edge after `ld_done` is seen high, `run_o` rises with step 0, opcode 0 and `ctl_o` set to the word at address 0.
- R8: A synchronous, active-high `rst` clears `ld_done`, so the store must be reloaded before running again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Loader write strobe |
| ld_addr | input | OP_W+STEP_W | Loader word address {opcode, line} |
| ld_data | input | CTL_W | Loader word |
| ld_done | output | 1 | Store fully loaded |
| ir_in | input | OP_W | Instruction register value |
| ctl_o | output | CTL_W | Current control word (registered) |
| step_o | output | STEP_W | Current microstep |
| op_o | output | OP_W | Latched opcode |
| run_o | output | 1 | Sequencer is executing microcode |

## Verification
Three situations are hard to reach from the ports. The first is a full 32-line walk with a wrap from line 31. The bench fills some opcode windows with no end bit at all and forces the instruction input to one of those opcodes, so every fetch captures it again. The second is a write that arrives after loading is finished. The bench issues a changed word for a line that the next forced opcode is certain to execute, then compares `ctl_o` on that line against the original contents. The third is a reset in the middle of execution, which is followed by a complete second load before random execution resumes.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  // Sequencer-control bits counted down from the top of a control word
  localparam int EOI_FROM_TOP  = 1;
  localparam int CAPT_FROM_TOP = 2;

  function automatic int eoi_pos(input int ctl_w);
    return ctl_w - EOI_FROM_TOP;
  endfunction

  function automatic int capt_pos(input int ctl_w);
    return ctl_w - CAPT_FROM_TOP;
  endfunction
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Synchronous read with a clearable output register
  always_ff @(posedge clk) begin
    if (clr) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/mseq_loader.sv
module mseq_loader #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              we_out,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  assign we_out = we_in & ~done;

  always_ff @(posedge clk) begin
    if (rst)                          done <= 1'b0;
    else if (we_out && addr_in == LAST) done <= 1'b1;
  end
endmodule

// File: rtl/mseq_stepper.sv
module mseq_stepper #(
  parameter int OP_W   = 6,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              hold,
  input  logic              eoi,
  input  logic              capt,
  input  logic [OP_W-1:0]   ir_in,
  output logic [STEP_W-1:0] step_q,
  output logic [OP_W-1:0]   op_q,
  output logic              act_q,
  output logic [STEP_W-1:0] nxt_step,
  output logic [OP_W-1:0]   nxt_op
);
  logic nxt_act;

  always_comb begin
    nxt_step = step_q;
    nxt_op   = op_q;
    nxt_act  = act_q;
    if (hold) begin
      nxt_step = '0;
      nxt_op   = '0;
      nxt_act  = 1'b0;
    end else if (!act_q) begin
      // priming cycle: fetch the word for line 0 of slot 0
      nxt_step = '0;
      nxt_op   = '0;
      nxt_act  = 1'b1;
    end else begin
      nxt_step = eoi ? '0 : step_q + STEP_W'(1);
      if (capt) nxt_op = ir_in;
    end
  end

  always_ff @(posedge clk) begin
    step_q <= nxt_step;
    op_q   <= nxt_op;
    act_q  <= nxt_act;
  end
endmodule

// File: rtl/mseq_top.sv
module mseq_top
  import mseq_pkg::*;
#(
  parameter int OP_W   = 6,
  parameter int STEP_W = 5,
  parameter int CTL_W  = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ld_we,
  input  logic [OP_W+STEP_W-1:0] ld_addr,
  input  logic [CTL_W-1:0]       ld_data,
  output logic                   ld_done,
  input  logic [OP_W-1:0]        ir_in,
  output logic [CTL_W-1:0]       ctl_o,
  output logic [STEP_W-1:0]      step_o,
  output logic [OP_W-1:0]        op_o,
  output logic                   run_o
);
  localparam int ADDR_W = OP_W + STEP_W;
  localparam int EOI_B  = eoi_pos(CTL_W);
  localparam int CAPT_B = capt_pos(CTL_W);

  logic              hold, st_we, eoi, capt;
  logic [STEP_W-1:0] nxt_step;
  logic [OP_W-1:0]   nxt_op;

  assign hold = rst | ~ld_done;
  assign eoi  = run_o & ctl_o[EOI_B];
  assign capt = run_o & ctl_o[CAPT_B];

  mseq_loader #(.ADDR_W(ADDR_W)) u_loader (
    .clk(clk), .rst(rst), .we_in(ld_we), .addr_in(ld_addr),
    .we_out(st_we), .done(ld_done)
  );

  mseq_stepper #(.OP_W(OP_W), .STEP_W(STEP_W)) u_step (
    .clk(clk), .hold(hold), .eoi(eoi), .capt(capt), .ir_in(ir_in),
    .step_q(step_o), .op_q(op_o), .act_q(run_o),
    .nxt_step(nxt_step), .nxt_op(nxt_op)
  );

  mseq_store #(.ADDR_W(ADDR_W), .DATA_W(CTL_W)) u_store (
    .clk(clk), .we(st_we), .waddr(ld_addr), .wdata(ld_data),
    .clr(hold), .raddr({nxt_op, nxt_step}), .rdata(ctl_o)
  );
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int OP_W   = 6,
  parameter int STEP_W = 5,
  parameter int CTL_W  = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_done,
  input logic [OP_W-1:0]   ir_in,
  input logic [CTL_W-1:0]  ctl_o,
  input logic [STEP_W-1:0] step_o,
  input logic [OP_W-1:0]   op_o,
  input logic              run_o
);
  localparam logic [STEP_W-1:0] SMAX = '1;

  a_r2_end_returns_zero: assert property (@(posedge clk) disable iff (rst)
    run_o && ctl_o[CTL_W-1] |=> step_o == '0);

  a_r2_step_increments: assert property (@(posedge clk) disable iff (rst)
    run_o && !ctl_o[CTL_W-1] && step_o != SMAX |=> step_o == $past(step_o) + 1'b1);

  a_r3_wrap_from_last: assert property (@(posedge clk) disable iff (rst)
    run_o && !ctl_o[CTL_W-1] && step_o == SMAX |=> step_o == '0);

  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    run_o && ctl_o[CTL_W-2] |=> op_o == $past(ir_in));

  a_r4_hold_opcode: assert property (@(posedge clk) disable iff (rst)
    run_o && !ctl_o[CTL_W-2] |=> $stable(op_o));

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    ld_done |=> ld_done);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !run_o |-> ctl_o == '0 && step_o == '0 && op_o == '0);

  a_r7_run_needs_load: assert property (@(posedge clk) disable iff (rst)
    run_o |-> ld_done);
endmodule

bind mseq_top mseq_chk #(.OP_W(OP_W), .STEP_W(STEP_W), .CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst(rst), .ld_done(ld_done), .ir_in(ir_in), .ctl_o(ctl_o),
  .step_o(step_o), .op_o(op_o), .run_o(run_o)
);

// File: tb/tb_mseq_top.sv
module tb_mseq_top;
  localparam int OP_W = 6, STEP_W = 5, CTL_W = 64;
  localparam int AW = OP_W + STEP_W, N = 1 << AW;
  localparam int EOI = CTL_W - 1, CAPT = CTL_W - 2, SMAX = 31;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst, ld_we, ld_done, run_o;
  logic [AW-1:0]     ld_addr;
  logic [CTL_W-1:0]  ld_data, ctl_o;
  logic [OP_W-1:0]   ir_in, op_o;
  logic [STEP_W-1:0] step_o;

  mseq_top #(.OP_W(OP_W), .STEP_W(STEP_W), .CTL_W(CTL_W)) dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .ld_done(ld_done), .ir_in(ir_in), .ctl_o(ctl_o), .step_o(step_o),
    .op_o(op_o), .run_o(run_o)
  );

  logic [CTL_W-1:0]  refm [N];
  logic [OP_W-1:0]   mop;
  logic [STEP_W-1:0] mstep;
  bit wrapped, tampered;
  int checks = 0, fails = 0;

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  function automatic logic [CTL_W-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  // Microcode image: shared fetch lines, varied execution lengths
  task automatic build();
    logic [CTL_W-1:0] f0, f1, f2;
    f0 = rnd_word(); f0[EOI] = 0; f0[CAPT] = 0;
    f1 = rnd_word(); f1[EOI] = 0; f1[CAPT] = 1;
    f2 = rnd_word(); f2[EOI] = 0; f2[CAPT] = 0;
    for (int o = 0; o < (1 << OP_W); o++) begin
      int len;
      if (o == 0)          len = 1;          // no-operation: one line after fetch
      else if (o % 7 == 3) len = 0;          // no end bit: walks every line
      else                 len = 1 + int'($urandom % 29);
      for (int l = 0; l < 32; l++) begin
        logic [CTL_W-1:0] w;
        if (l == 0) w = f0;
        else if (l == 1) w = f1;
        else if (l == 2) w = f2;
        else begin
          w = rnd_word(); w[CAPT] = 0;
          w[EOI] = (len > 0 && l == 2 + len);
        end
        refm[o * 32 + l] = w;
      end
    end
  endtask

  task automatic load();
    for (int a = 0; a < N; a++) begin
      if (a == N / 2) begin
        chk(ld_done == 0, "R5 partial", 64'(ld_done), 64'd0);
        chk(run_o == 0 && step_o == 0 && ctl_o == 0, "R7 partial", 64'(run_o), 64'd0);
      end
      ld_we = 1; ld_addr = AW'(a); ld_data = refm[a];
      @(negedge clk);
    end
    ld_we = 0;
    chk(ld_done == 1, "R5 done", 64'(ld_done), 64'd1);
    chk(run_o == 0, "R7 prime", 64'(run_o), 64'd0);
    @(negedge clk);
    chk(run_o == 1, "R7 start", 64'(run_o), 64'd1);
    chk(step_o == 0 && op_o == 0, "R7 start step", 64'({op_o, step_o}), 64'd0);
    chk(ctl_o == refm[0], "R7 start word", ctl_o, refm[0]);
    mop = '0; mstep = '0; wrapped = 0;
  endtask

  task automatic run(input int n, input int force_op, input bit tamper);
    for (int i = 0; i < n; i++) begin
      logic [CTL_W-1:0] w;
      logic [OP_W-1:0] ir;
      w = refm[{mop, mstep}];
      chk(ctl_o == w, (tampered && mop == 5 && mstep == 3) ? "R6" : "R1", ctl_o, w);
      chk(step_o == mstep, wrapped ? "R3" : "R2", 64'(step_o), 64'(mstep));
      chk(op_o == mop, "R4", 64'(op_o), 64'(mop));
      if (tamper && i == 0) begin
        ld_we = 1; ld_addr = {6'd5, 5'd3}; ld_data = ~refm[{6'd5, 5'd3}];
        tampered = 1;
      end else ld_we = 0;
      if (force_op >= 0) ir = OP_W'(force_op);
      else if ($urandom % 4 == 0) ir = '0;
      else ir = OP_W'($urandom);
      ir_in = ir;
      wrapped = !w[EOI] && mstep == STEP_W'(SMAX);
      mstep = w[EOI] ? '0 : mstep + 1'b1;
      if (w[CAPT]) mop = ir;
      @(negedge clk);
    end
    ld_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1; ld_we = 0; ld_addr = '0; ld_data = '0; ir_in = '0;
    tampered = 0; wrapped = 0;
    repeat (3) @(negedge clk);
    chk(ld_done == 0, "R5 reset", 64'(ld_done), 64'd0);
    chk(run_o == 0 && step_o == 0 && op_o == 0, "R7 reset", 64'(run_o), 64'd0);
    chk(ctl_o == 0, "R7 reset word", ctl_o, 64'd0);
    build();
    rst = 0;
    @(negedge clk);
    load();
    run(300, -1, 0);
    run(80, 0, 0);          // R2: four-line instruction repeated
    run(200, 3, 0);         // R3: full walk and wrap
    run(300, 5, 1);         // R6: late write must not land
    chk(ld_done == 1, "R5 sticky", 64'(ld_done), 64'd1);
    run(2000, -1, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(ld_done == 0, "R8 done cleared", 64'(ld_done), 64'd0);
    chk(run_o == 0 && step_o == 0, "R8 idle", 64'(run_o), 64'd0);
    chk(ctl_o == 0, "R8 word", ctl_o, 64'd0);
    tampered = 0;
    load();
    run(500, -1, 0);
    summary();
    $finish;
  end
endmodule